// File: doc/BRIEF.md
# Translator Fault Control and Status Register

This block is the single 32-bit control and status word of an address translator. Software uses it to turn the translator on, to route every access around translation, and to pick how each of three fault classes is answered. The classes are an access beyond the address limit ("cap"), a missing or invalid page-table entry ("pt") and a write to a read-only page ("wr"). Each class owns one sticky status bit plus three response enables: abort, interrupt and exception. The translator reports a fault by pulsing the input for that class during the faulting transaction. The block answers with an abort in the same cycle, and its interrupt and exception levels hold until software clears the status.

Writes arrive on a simple bus: a one-cycle write strobe with a data word. The register value is always visible on the read data port, and reading has no side effects. Two bits of a write are commands rather than state. They produce one-cycle pulses that clear the translation cache and the statistics counters, and they can share a write with status clearing.

Top module: `xlatFaultCsr`

## Requirements
- R1: After reset the register reads 0x00000000 and all outputs (unitEnable, bypassAll, abortReq, irqReq, excReq, tlbClearPulse, statsClearPulse) are low.
- R2: A write stores the configuration bits and they read back unchanged. The unit enable is bit 0 and bypass is bit 8. The pt detection enable is bit 16. The cap abort, interrupt and exception enables are bits 26, 25 and 24. The pt ones are bits 19, 18 and 17, and the wr ones are bits 11, 10 and 9. Every other bit reads 0, including the command bits 2 and 3.
- R3: A fault pulse of an accepted class sets its sticky status bit from the next cycle on: cap at bit 27, pt at bit 20, wr at bit 12. The bit then holds until it is cleared.
- R4: Writing 1 to a status bit clears it. Writing 0 to a status bit leaves it unchanged.
- R5: When a fault pulse and a write-1 clear of the same class meet in one cycle, the status bit ends up set.
- R6: While bit 16 is 0, pt fault pulses are ignored: pt status does not set and no abort is raised.
- R7: While bit 0 is 0, all fault pulses are ignored: no status bit sets and abortReq stays low.
- R8: abortReq is high in the same cycle as an accepted fault pulse whose class abort enable is set, and low otherwise.
- R9: irqReq is the OR over the classes of status AND interrupt enable. excReq is the same using the exception enables. Both are levels taken from the stored register.
- R10: A write with bit 2 set drives tlbClearPulse high for exactly the cycle after the write. Bit 3 does the same for statsClearPulse. Both can share one write with status clears.
- R11: unitEnable follows bit 0 and bypassAll follows bit 8. A write of zero disables the unit and drops every enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busWrite | input | 1 | Write strobe, one cycle per write |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Current register value |
| capFault | input | 1 | Address-cap fault pulse |
| ptFault | input | 1 | Page-table-invalid fault pulse |
| wrFault | input | 1 | Write-violation fault pulse |
| unitEnable | output | 1 | Translator enable |
| bypassAll | output | 1 | Route all accesses untranslated |
| abortReq | output | 1 | Abort the faulting transaction (same cycle) |
| irqReq | output | 1 | Interrupt request level |
| excReq | output | 1 | Exception request level |
| tlbClearPulse | output | 1 | One-cycle translation cache clear |
| statsClearPulse | output | 1 | One-cycle statistics clear |

## Verification
Some rules are checked on every cycle. An abort never appears without a fault pulse or while the unit is off, and an accepted cap fault always leaves its status set even under a same-cycle clear. A pt fault cannot set status while detection is off, a status bit never drops without a write, and the interrupt never rises with all status bits clear. A cache clear pulse is always preceded by a write that asked for it.

Other behaviour needs the bench's scenarios and its reference model. Exact readback of every configuration bit, 0-versus-1 write semantics on status bits, and the disable-by-zero write are shown this way. So are the per-class mapping of interrupt and exception enables and the exact single-cycle width of the command pulses.

// File: rtl/xlatFaultPkg.sv
package xlatFaultPkg;

  localparam int REG_W     = 32;
  localparam int NUM_CLASS = 3;

  // class index: 0 = address cap, 1 = page-table invalid, 2 = write violation
  localparam int CLS_CAP = 0;
  localparam int CLS_PT  = 1;
  localparam int CLS_WR  = 2;

  localparam int BIT_UNIT_EN   = 0;
  localparam int BIT_TLB_CLR   = 2;
  localparam int BIT_STATS_CLR = 3;
  localparam int BIT_BYPASS    = 8;
  localparam int BIT_PT_DETECT = 16;

  // status bit of a class; its abort, interrupt and exception enables
  // sit at the next three lower positions
  function automatic int statusBit(input int cls);
    case (cls)
      CLS_CAP: statusBit = 27;
      CLS_PT:  statusBit = 20;
      default: statusBit = 12;
    endcase
  endfunction

  // bits that hold configuration (stored as written)
  function automatic logic [REG_W-1:0] cfgMask();
    logic [REG_W-1:0] m;
    m = '0;
    m[BIT_UNIT_EN]   = 1'b1;
    m[BIT_BYPASS]    = 1'b1;
    m[BIT_PT_DETECT] = 1'b1;
    for (int c = 0; c < NUM_CLASS; c++) begin
      m[statusBit(c)-1] = 1'b1;
      m[statusBit(c)-2] = 1'b1;
      m[statusBit(c)-3] = 1'b1;
    end
    return m;
  endfunction

  typedef struct packed {
    logic                 loadCfg;
    logic [REG_W-1:0]     cfgData;
    logic [NUM_CLASS-1:0] clrSticky;
  } csrStrobes_t;

endpackage

// File: rtl/xlatFaultCtrl.sv
module xlatFaultCtrl
  import xlatFaultPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             busWrite,
  input  logic [REG_W-1:0] busWdata,
  output csrStrobes_t      strb,
  output logic             tlbClearPulse,
  output logic             statsClearPulse
);

  localparam logic [REG_W-1:0] CFG_MASK = cfgMask();

  logic [NUM_CLASS-1:0] clrVec;

  for (genvar c = 0; c < NUM_CLASS; c++) begin : g_clr
    localparam int SB = statusBit(c);
    assign clrVec[c] = busWrite & busWdata[SB];
  end

  always_comb begin
    strb.loadCfg   = busWrite;
    strb.cfgData   = busWdata & CFG_MASK;
    strb.clrSticky = clrVec;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tlbClearPulse   <= 1'b0;
      statsClearPulse <= 1'b0;
    end else begin
      tlbClearPulse   <= busWrite & busWdata[BIT_TLB_CLR];
      statsClearPulse <= busWrite & busWdata[BIT_STATS_CLR];
    end
  end

endmodule

// File: rtl/xlatFaultDp.sv
module xlatFaultDp
  import xlatFaultPkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  csrStrobes_t          strb,
  input  logic [NUM_CLASS-1:0] faultIn,
  output logic [REG_W-1:0]     regValue,
  output logic                 unitEnable,
  output logic                 bypassAll,
  output logic                 abortReq,
  output logic                 irqReq,
  output logic                 excReq
);

  logic [REG_W-1:0]     cfgQ;
  logic [NUM_CLASS-1:0] stickyQ;
  logic [NUM_CLASS-1:0] faultSeen;
  logic [NUM_CLASS-1:0] abortEn;
  logic [NUM_CLASS-1:0] intEn;
  logic [NUM_CLASS-1:0] excEn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cfgQ <= '0;
    else if (strb.loadCfg) cfgQ <= strb.cfgData;
  end

  for (genvar c = 0; c < NUM_CLASS; c++) begin : g_cls
    localparam int SB = statusBit(c);
    logic gateOk;

    if (c == CLS_PT) begin : g_det
      assign gateOk = cfgQ[BIT_PT_DETECT];
    end else begin : g_nodet
      assign gateOk = 1'b1;
    end

    assign abortEn[c]   = cfgQ[SB-1];
    assign intEn[c]     = cfgQ[SB-2];
    assign excEn[c]     = cfgQ[SB-3];
    assign faultSeen[c] = faultIn[c] & cfgQ[BIT_UNIT_EN] & gateOk;

    // set has priority over a same-cycle write-1 clear
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stickyQ[c] <= 1'b0;
      else       stickyQ[c] <= (stickyQ[c] & ~strb.clrSticky[c]) | faultSeen[c];
    end
  end

  always_comb begin
    regValue = cfgQ;
    for (int c = 0; c < NUM_CLASS; c++) begin
      regValue[statusBit(c)] = stickyQ[c];
    end
  end

  assign unitEnable = cfgQ[BIT_UNIT_EN];
  assign bypassAll  = cfgQ[BIT_BYPASS];
  assign abortReq   = |(faultSeen & abortEn);
  assign irqReq     = |(stickyQ & intEn);
  assign excReq     = |(stickyQ & excEn);

endmodule

// File: rtl/xlatFaultCsr.sv
module xlatFaultCsr
  import xlatFaultPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             busWrite,
  input  logic [REG_W-1:0] busWdata,
  output logic [REG_W-1:0] busRdata,
  input  logic             capFault,
  input  logic             ptFault,
  input  logic             wrFault,
  output logic             unitEnable,
  output logic             bypassAll,
  output logic             abortReq,
  output logic             irqReq,
  output logic             excReq,
  output logic             tlbClearPulse,
  output logic             statsClearPulse
);

  csrStrobes_t          strb;
  logic [NUM_CLASS-1:0] faultVec;

  always_comb begin
    faultVec         = '0;
    faultVec[CLS_CAP] = capFault;
    faultVec[CLS_PT]  = ptFault;
    faultVec[CLS_WR]  = wrFault;
  end

  xlatFaultCtrl u_ctrl (
    .clk             (clk),
    .rstN            (rstN),
    .busWrite        (busWrite),
    .busWdata        (busWdata),
    .strb            (strb),
    .tlbClearPulse   (tlbClearPulse),
    .statsClearPulse (statsClearPulse)
  );

  xlatFaultDp u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .faultIn    (faultVec),
    .regValue   (busRdata),
    .unitEnable (unitEnable),
    .bypassAll  (bypassAll),
    .abortReq   (abortReq),
    .irqReq     (irqReq),
    .excReq     (excReq)
  );

endmodule

// File: rtl/xlatFaultChk.sv
module xlatFaultChk (
  input logic        clk,
  input logic        rstN,
  input logic        busWrite,
  input logic [31:0] busWdata,
  input logic [31:0] busRdata,
  input logic        capFault,
  input logic        ptFault,
  input logic        wrFault,
  input logic        unitEnable,
  input logic        bypassAll,
  input logic        abortReq,
  input logic        irqReq,
  input logic        excReq,
  input logic        tlbClearPulse,
  input logic        statsClearPulse
);

  AST_ABORT_NEEDS_FAULT: assert property (@(posedge clk) disable iff (!rstN)
    abortReq |-> (capFault || ptFault || wrFault)); // R8

  AST_OFF_NO_ABORT: assert property (@(posedge clk) disable iff (!rstN)
    !unitEnable |-> !abortReq); // R7

  AST_CAP_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    (capFault && unitEnable) |=> busRdata[27]); // R5

  AST_PT_GATED: assert property (@(posedge clk) disable iff (!rstN)
    (!busRdata[16] && !busRdata[20]) |=> !busRdata[20]); // R6

  AST_STICKY_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (!busWrite && busRdata[12]) |=> busRdata[12]); // R3

  AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> (busRdata[27] || busRdata[20] || busRdata[12])); // R9

  AST_TLB_PULSE_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    tlbClearPulse |-> $past(busWrite && busWdata[2])); // R10

endmodule

bind xlatFaultCsr xlatFaultChk u_chk (.*);

// File: tb/xlatFaultCsr_tb.sv
module xlatFaultCsr_tb;

  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] CFG_MASK = 32'h070F_0F01;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrite = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        capFault = 1'b0, ptFault = 1'b0, wrFault = 1'b0;
  logic        unitEnable, bypassAll, abortReq, irqReq, excReq;
  logic        tlbClearPulse, statsClearPulse;

  int nChecks = 0;
  int nFail = 0;
  logic [31:0] mCfg = '0;
  logic [2:0]  mSticky = '0;  // [0]=cap [1]=pt [2]=wr

  always #(CLK_PERIOD/2) clk = ~clk;

  xlatFaultCsr u_dut (.*);

  function automatic logic [31:0] expReg();
    logic [31:0] v;
    v = mCfg;
    v[27] = mSticky[0];
    v[20] = mSticky[1];
    v[12] = mSticky[2];
    return v;
  endfunction

  function automatic logic expIrq();
    return (mSticky[0] & mCfg[25]) | (mSticky[1] & mCfg[18]) | (mSticky[2] & mCfg[10]);
  endfunction

  function automatic logic expExc();
    return (mSticky[0] & mCfg[24]) | (mSticky[1] & mCfg[17]) | (mSticky[2] & mCfg[9]);
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // drive one cycle, check the same-cycle abort, then every registered result
  task automatic stepCycle(input logic w, input logic [31:0] d,
                           input logic [2:0] f, input string tag);
    logic [2:0] seen;
    logic [2:0] clr;
    logic abortE;
    @(negedge clk);
    busWrite = w; busWdata = d;
    capFault = f[0]; ptFault = f[1]; wrFault = f[2];
    seen[0] = f[0] & mCfg[0];
    seen[1] = f[1] & mCfg[0] & mCfg[16];
    seen[2] = f[2] & mCfg[0];
    abortE = (seen[0] & mCfg[26]) | (seen[1] & mCfg[19]) | (seen[2] & mCfg[11]);
    #1;
    chk(tag, "abortReq", {31'b0, abortReq}, {31'b0, abortE});
    @(posedge clk);
    #1;
    clr = w ? {d[12], d[20], d[27]} : 3'b000;
    mSticky = (mSticky & ~clr) | seen;
    if (w) mCfg = d & CFG_MASK;
    chk(tag, "busRdata", busRdata, expReg());
    chk(tag, "irqReq", {31'b0, irqReq}, {31'b0, expIrq()});
    chk(tag, "excReq", {31'b0, excReq}, {31'b0, expExc()});
    chk(tag, "unitEnable", {31'b0, unitEnable}, {31'b0, mCfg[0]});
    chk(tag, "bypassAll", {31'b0, bypassAll}, {31'b0, mCfg[8]});
    chk(tag, "tlbClearPulse", {31'b0, tlbClearPulse}, {31'b0, w & d[2]});
    chk(tag, "statsClearPulse", {31'b0, statsClearPulse}, {31'b0, w & d[3]});
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nFail++;
    nChecks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    int unsigned seedDummy;
    seedDummy = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    #1;
    chk("R1", "busRdata in reset", busRdata, 32'h0);
    rstN = 1'b1;
    @(negedge clk); #1;
    chk("R1", "busRdata", busRdata, 32'h0);
    chk("R1", "outputs", {25'b0, unitEnable, bypassAll, abortReq, irqReq, excReq,
                          tlbClearPulse, statsClearPulse}, 32'h0);

    // all ones: only configuration bits stay, pulses fire
    stepCycle(1'b1, 32'hFFFF_FFFF, 3'b000, "R2/R10 all-ones");
    stepCycle(1'b0, 32'h0, 3'b000, "R10 pulse ends");
    stepCycle(1'b1, 32'h070F_0F01, 3'b000, "R2 cfg");
    // each class faults once
    stepCycle(1'b0, 32'h0, 3'b001, "R3/R8 cap");
    stepCycle(1'b0, 32'h0, 3'b010, "R3/R8 pt");
    stepCycle(1'b0, 32'h0, 3'b100, "R3/R9 wr");
    // write zeros to status: no effect
    stepCycle(1'b1, 32'h070F_0F01, 3'b000, "R4 write0");
    // clear only pt status
    stepCycle(1'b1, 32'h071F_0F01, 3'b000, "R4 clear pt");
    // clear cap while cap faults: set wins
    stepCycle(1'b1, 32'h0F0F_0F01, 3'b001, "R5 set wins");
    // clear everything plus both commands in one write
    stepCycle(1'b1, 32'h0F1F_1F0D, 3'b000, "R10 combined");
    // interrupt only for wr class
    stepCycle(1'b1, 32'h0000_0401, 3'b000, "R9 cfg");
    stepCycle(1'b0, 32'h0, 3'b101, "R9 wr irq");
    // pt detection off
    stepCycle(1'b1, 32'h0008_1401, 3'b000, "R6 cfg");
    stepCycle(1'b0, 32'h0, 3'b010, "R6 pt ignored");
    // unit off
    stepCycle(1'b1, 32'h070F_0F00, 3'b000, "R7 cfg");
    stepCycle(1'b0, 32'h0, 3'b111, "R7 ignored");
    stepCycle(1'b1, 32'h0000_0101, 3'b000, "R11 bypass");
    stepCycle(1'b1, 32'h0, 3'b000, "R11 write zero");
    stepCycle(1'b0, 32'h0, 3'b111, "R11 disabled");

    for (int i = 0; i < 600; i++) begin
      logic w;
      logic [31:0] d;
      logic [2:0] f;
      w = ($urandom % 4) == 0;
      d = $urandom;
      if (($urandom % 4) != 0) d[0] = 1'b1;
      f = 3'($urandom) & 3'($urandom);
      stepCycle(w, d, f, "RND R2/R3/R4/R8/R9/R10/R11");
    end

    @(negedge clk);
    busWrite = 1'b0; capFault = 1'b0; ptFault = 1'b0; wrFault = 1'b0;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule